// File: doc/BRIEF.md
# Chip-Select Driven Dynamic Bus Sizer

This block sits between a 16-bit processor bus and the external memory bus and decides, access by access, whether the external port behind the target is 8 or 16 bits wide. The decision comes from whichever chip-select region the address falls in, so narrow boot memory, wide RAM and byte-wide peripherals can share one bus with no size-handshake pins. Each region's width is fixed by configuration: chip select 0 takes its width from a pin sampled while reset is held, and the other three take theirs from configuration bits. Accesses that hit no region use a separate configurable width and wait for an external acknowledge.

A word access to an 8-bit region is split into two byte cycles on the upper data lane: the even byte first, then the odd byte. The read data is reassembled into one 16-bit word before completion is signalled. Accesses to the internal peripheral range never reach the external bus. During processor-space cycles (function code all ones) every chip-select match is ignored, so those cycles fall to the unmatched path.

Top module: `bus_sizer`

## Requirements
- R1: While reset is held and in the cycle after it is released, `ext_as`, `ext_uds`, `ext_lds` and `core_done` are low.
- R2: The width of chip select 0 (match bit 0) is the value of `busw_pin` during reset (0 = 8-bit, 1 = 16-bit). Changing the pin after reset has no effect.
- R3: The widths of chip selects on match bits 1, 2 and 3 come from `cfg_cs_wide` bits 0, 1 and 2 respectively (1 = 16-bit, 0 = 8-bit).
- R4: An access that hits no chip select and no peripheral range uses width `cfg_ext_wide` (1 = 16-bit, 0 = 8-bit). Each of its external cycles ends only after `ext_dtack` has been sampled high.
- R5: An external cycle in a chip-select region keeps `ext_as` high for exactly CS_WAIT+1 clock cycles (3 by default), whatever `ext_dtack` does.
- R6: A word access (both byte strobes) to an 8-bit port gives two external cycles separated by at least one cycle with `ext_as` low. The first is at the even byte address and the second at that address plus one.
- R7: On every 8-bit cycle, `ext_narrow` is 1, `ext_uds` is 1, `ext_lds` is 0, and the byte travels on `ext_wdata[15:8]`/`ext_rdata[15:8]` with `ext_wdata[7:0]` = 0. The even byte comes from `core_wdata[15:8]` and the odd byte from `core_wdata[7:0]`.
- R8: A single-byte access to an 8-bit port gives exactly one external cycle. Its address bit 0 is 0 for `core_uds` and 1 for `core_lds`.
- R9: For a read, `core_rdata` at completion holds `ext_rdata` for a 16-bit cycle. For an 8-bit port it holds the even byte in [15:8] and the odd byte in [7:0], with any byte that was not requested reading zero.
- R10: An access with `per_hit` set produces no external cycle. `core_done` rises two clocks after the request is accepted, with `core_rdata` = `per_rdata`.
- R11: When `core_fc` is 3'b111, `cs_hit` is ignored and the access is treated as unmatched.
- R12: When several chip-select matches are set, the lowest-numbered one sets the width. `core_done` is a single-cycle pulse.
- R13: A 16-bit external cycle copies the core byte strobes and write word unchanged, with address bit 0 equal to 0, and it is a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busw_pin | input | 1 | Chip select 0 width, sampled during reset |
| cfg_cs_wide | input | NCS-1 | Width bits for chip selects 1..NCS-1 |
| cfg_ext_wide | input | 1 | Width for unmatched accesses |
| core_req | input | 1 | Access request, held until `core_done` |
| core_addr | input | AW-1 | Word address (byte address bits AW-1:1) |
| core_rw | input | 1 | 1 = read, 0 = write |
| core_uds | input | 1 | Even (upper) byte strobe |
| core_lds | input | 1 | Odd (lower) byte strobe |
| core_wdata | input | DW | Write word |
| core_fc | input | 3 | Function code |
| cs_hit | input | NCS | Chip-select match lines |
| per_hit | input | 1 | Internal peripheral range match |
| per_rdata | input | DW | Peripheral read data |
| core_rdata | output | DW | Assembled read word |
| core_done | output | 1 | Access completion pulse |
| ext_as | output | 1 | External address strobe |
| ext_addr | output | AW | External byte address |
| ext_rw | output | 1 | External read/write |
| ext_uds | output | 1 | External upper byte strobe |
| ext_lds | output | 1 | External lower byte strobe |
| ext_narrow | output | 1 | Current cycle uses the 8-bit lane |
| ext_wdata | output | DW | External write data |
| ext_rdata | input | DW | External read data |
| ext_dtack | input | 1 | External transfer acknowledge |

## Verification
The checker watches four rules on every cycle: lane discipline on 8-bit cycles, the even address bit on 16-bit cycles, the rule that an unmatched cycle cannot end without the external acknowledge, and the absence of any strobe while a peripheral access is in progress. It also checks that completion never lasts two cycles. The bench scenarios cover what needs a whole access to see: the order of the split addresses, the reassembled read word, the strobe length of chip-select cycles, the width taken from the reset pin versus the configuration bits, match priority, and suppression during processor-space cycles.

// File: rtl/bsz_pkg.sv
`timescale 1ns/100ps
package bsz_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BUS  = 3'd1,
    ST_GAP  = 3'd2,
    ST_PER  = 3'd3,
    ST_DONE = 3'd4
  } bsz_state_e;
endpackage

// File: rtl/bsz_width_sel.sv
`timescale 1ns/100ps
module bsz_width_sel #(
  parameter int NCS = 4
) (
  input  logic [NCS-1:0] cs_hit,
  input  logic [2:0]     fc,
  input  logic [NCS-1:0] cs_wide,
  input  logic           ext_wide,
  output logic           matched,
  output logic           wide
);
  logic [NCS-1:0] hit_ok;

  always_comb begin
    hit_ok  = (fc == 3'b111) ? '0 : cs_hit;
    matched = |hit_ok;
    wide    = ext_wide;
    // walk downward so the lowest matching index wins
    for (int i = NCS - 1; i >= 0; i--) begin
      if (hit_ok[i]) wide = cs_wide[i];
    end
  end
endmodule

// File: rtl/bsz_lane.sv
`timescale 1ns/100ps
module bsz_lane #(
  parameter int DW = 16
) (
  input  logic          narrow,
  input  logic          second,
  input  logic          uds,
  input  logic          lds,
  input  logic [DW-1:0] wdata,
  output logic          o_uds,
  output logic          o_lds,
  output logic          o_a0,
  output logic [DW-1:0] o_wdata
);
  localparam int BW = DW / 2;
  logic pick_odd;

  always_comb begin
    pick_odd = second | ~uds;
    if (narrow) begin
      o_uds   = 1'b1;
      o_lds   = 1'b0;
      o_a0    = pick_odd;
      o_wdata = {(pick_odd ? wdata[BW-1:0] : wdata[DW-1:BW]), {BW{1'b0}}};
    end else begin
      o_uds   = uds;
      o_lds   = lds;
      o_a0    = 1'b0;
      o_wdata = wdata;
    end
  end
endmodule

// File: rtl/bus_sizer.sv
`timescale 1ns/100ps
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int NCS     = 4,
  parameter int CS_WAIT = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           busw_pin,
  input  logic [NCS-2:0] cfg_cs_wide,
  input  logic           cfg_ext_wide,
  input  logic           core_req,
  input  logic [AW-1:1]  core_addr,
  input  logic           core_rw,
  input  logic           core_uds,
  input  logic           core_lds,
  input  logic [DW-1:0]  core_wdata,
  input  logic [2:0]     core_fc,
  input  logic [NCS-1:0] cs_hit,
  input  logic           per_hit,
  input  logic [DW-1:0]  per_rdata,
  output logic [DW-1:0]  core_rdata,
  output logic           core_done,
  output logic           ext_as,
  output logic [AW-1:0]  ext_addr,
  output logic           ext_rw,
  output logic           ext_uds,
  output logic           ext_lds,
  output logic           ext_narrow,
  output logic [DW-1:0]  ext_wdata,
  input  logic [DW-1:0]  ext_rdata,
  input  logic           ext_dtack
);
  localparam int BW    = DW / 2;
  localparam int CNT_W = $clog2(CS_WAIT + 1) + 1;

  // chip select 0 width follows the pin for as long as reset is held
  logic cs0_wide;
  always_ff @(posedge clk) begin
    if (rst) cs0_wide <= busw_pin;
  end

  logic [NCS-1:0] cs_wide;
  generate
    for (genvar g = 0; g < NCS; g++) begin : g_wide
      if (g == 0) begin : g_pin
        assign cs_wide[g] = cs0_wide;
      end else begin : g_cfg
        assign cs_wide[g] = cfg_cs_wide[g-1];
      end
    end
  endgenerate

  logic sel_matched, sel_wide;
  bsz_width_sel #(.NCS(NCS)) u_wsel (
    .cs_hit   (cs_hit),
    .fc       (core_fc),
    .cs_wide  (cs_wide),
    .ext_wide (cfg_ext_wide),
    .matched  (sel_matched),
    .wide     (sel_wide)
  );

  bsz_state_e       state;
  logic             narrow_q, matched_q, split_q, second_q;
  logic             uds_q, lds_q;
  logic [AW-1:1]    addr_q;
  logic [DW-1:0]    wdata_q, asm_q, asm_next;
  logic [CNT_W-1:0] cnt;
  logic             idle, term;

  logic          ln_narrow, ln_second, ln_uds, ln_lds;
  logic [DW-1:0] ln_wdata;
  logic          lo_uds, lo_lds, lo_a0;
  logic [DW-1:0] lo_wdata;

  // in idle the lane logic sees the live request, afterwards the latched one
  always_comb begin
    idle      = (state == ST_IDLE);
    ln_narrow = idle ? ~sel_wide   : narrow_q;
    ln_second = ~idle;
    ln_uds    = idle ? core_uds    : uds_q;
    ln_lds    = idle ? core_lds    : lds_q;
    ln_wdata  = idle ? core_wdata  : wdata_q;
  end

  bsz_lane #(.DW(DW)) u_lane (
    .narrow  (ln_narrow),
    .second  (ln_second),
    .uds     (ln_uds),
    .lds     (ln_lds),
    .wdata   (ln_wdata),
    .o_uds   (lo_uds),
    .o_lds   (lo_lds),
    .o_a0    (lo_a0),
    .o_wdata (lo_wdata)
  );

  always_comb begin
    term = matched_q ? (cnt == CNT_W'(CS_WAIT)) : ext_dtack;
    if (ext_addr[0]) asm_next = {asm_q[DW-1:BW], ext_rdata[DW-1:BW]};
    else             asm_next = {ext_rdata[DW-1:BW], asm_q[BW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      narrow_q   <= 1'b0;
      matched_q  <= 1'b0;
      split_q    <= 1'b0;
      second_q   <= 1'b0;
      uds_q      <= 1'b0;
      lds_q      <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      asm_q      <= '0;
      cnt        <= '0;
      core_rdata <= '0;
      core_done  <= 1'b0;
      ext_as     <= 1'b0;
      ext_addr   <= '0;
      ext_rw     <= 1'b1;
      ext_uds    <= 1'b0;
      ext_lds    <= 1'b0;
      ext_narrow <= 1'b0;
      ext_wdata  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (core_req) begin
            uds_q   <= core_uds;
            lds_q   <= core_lds;
            addr_q  <= core_addr;
            wdata_q <= core_wdata;
            if (per_hit) begin
              state <= ST_PER;
            end else begin
              narrow_q   <= ~sel_wide;
              matched_q  <= sel_matched;
              split_q    <= ~sel_wide & core_uds & core_lds;
              second_q   <= 1'b0;
              cnt        <= '0;
              asm_q      <= '0;
              ext_as     <= 1'b1;
              ext_addr   <= {core_addr, lo_a0};
              ext_rw     <= core_rw;
              ext_uds    <= lo_uds;
              ext_lds    <= lo_lds;
              ext_narrow <= ~sel_wide;
              ext_wdata  <= lo_wdata;
              state      <= ST_BUS;
            end
          end
        end
        ST_BUS: begin
          if (term) begin
            asm_q   <= asm_next;
            ext_as  <= 1'b0;
            ext_uds <= 1'b0;
            ext_lds <= 1'b0;
            if (split_q && !second_q) begin
              second_q <= 1'b1;
              state    <= ST_GAP;
            end else begin
              core_done  <= 1'b1;
              core_rdata <= narrow_q ? asm_next : ext_rdata;
              state      <= ST_DONE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_GAP: begin
          cnt       <= '0;
          ext_as    <= 1'b1;
          ext_addr  <= {addr_q, lo_a0};
          ext_uds   <= lo_uds;
          ext_lds   <= lo_lds;
          ext_wdata <= lo_wdata;
          state     <= ST_BUS;
        end
        ST_PER: begin
          core_rdata <= per_rdata;
          core_done  <= 1'b1;
          state      <= ST_DONE;
        end
        ST_DONE: begin
          core_done <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsz_checker.sv
`timescale 1ns/100ps
module bsz_checker
  import bsz_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ext_as,
  input logic          ext_narrow,
  input logic          ext_uds,
  input logic          ext_lds,
  input logic [DW-1:0] ext_wdata,
  input logic [AW-1:0] ext_addr,
  input logic          ext_dtack,
  input logic          core_done,
  input logic          matched_q,
  input bsz_state_e    state
);
  localparam int BW = DW / 2;

  // R7
  narrow_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_as && ext_narrow) |-> (ext_uds && !ext_lds && ext_wdata[BW-1:0] == '0));

  // R13
  wide_even_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_as && !ext_narrow) |-> (ext_addr[0] == 1'b0));

  // R4
  dtack_needed_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_as && !matched_q && !ext_dtack) |=> ext_as);

  // R10
  per_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PER) |-> !ext_as);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    core_done |=> !core_done);
endmodule

bind bus_sizer bsz_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/bus_sizer_bench.sv
`timescale 1ns/100ps
module bus_sizer_bench;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int NCS = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst = 1'b1;
  logic           busw_pin = 1'b0;
  logic [NCS-2:0] cfg_cs_wide = '1;
  logic           cfg_ext_wide = 1'b1;
  logic           core_req = 1'b0;
  logic [AW-1:1]  core_addr = '0;
  logic           core_rw = 1'b1, core_uds = 1'b0, core_lds = 1'b0;
  logic [DW-1:0]  core_wdata = '0;
  logic [2:0]     core_fc = 3'b101;
  logic [NCS-1:0] cs_hit = '0;
  logic           per_hit = 1'b0;
  logic [DW-1:0]  per_rdata = '0;
  logic [DW-1:0]  core_rdata;
  logic           core_done, ext_as, ext_rw, ext_uds, ext_lds, ext_narrow;
  logic [AW-1:0]  ext_addr;
  logic [DW-1:0]  ext_wdata, ext_rdata;
  logic           ext_dtack = 1'b0;

  // external memory model: each byte address returns a known pattern
  assign ext_rdata = {ext_addr[7:0] ^ 8'hA5, ext_addr[7:0] ^ 8'h3C};

  bus_sizer #(.AW(AW), .DW(DW), .NCS(NCS), .CS_WAIT(2)) u_bus_sizer (.*);

  int n_chk = 0, n_bad = 0;
  int nruns, waited;
  logic [AW-1:0] run_addr [4];
  int            run_len  [4];
  logic          run_uds  [4], run_lds [4], run_nar [4];
  logic [DW-1:0] run_wd   [4];
  logic [DW-1:0] got;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wide_rd(input logic [AW-1:0] x);
    return {x[7:0] ^ 8'hA5, x[7:0] ^ 8'h3C};
  endfunction
  function automatic logic [7:0] byte_rd(input logic [AW-1:0] x);
    return x[7:0] ^ 8'hA5;
  endfunction

  task automatic do_reset(input logic pin);
    busw_pin = pin;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ext_as && !ext_uds && !ext_lds && !core_done, "R1 in reset", ext_as, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!ext_as && !ext_uds && !ext_lds && !core_done, "R1 after reset", core_done, 0);
  endtask

  task automatic access(input logic [AW-1:0] ab, input logic u, input logic l, input logic rw,
                        input logic [15:0] w, input logic [3:0] hit, input logic per,
                        input logic [2:0] fc, input int dt);
    bit prev = 0;
    int dtc = 0;
    nruns = 0; waited = 0;
    for (int i = 0; i < 4; i++) begin run_len[i] = 0; run_addr[i] = '0; end
    core_addr = ab[AW-1:1]; core_uds = u; core_lds = l; core_rw = rw;
    core_wdata = w; cs_hit = hit; per_hit = per; core_fc = fc;
    core_req = 1'b1;
    forever begin
      @(negedge clk);
      waited++;
      if (ext_as) begin
        if (!prev && nruns < 4) begin
          run_addr[nruns] = ext_addr; run_uds[nruns] = ext_uds; run_lds[nruns] = ext_lds;
          run_nar[nruns] = ext_narrow; run_wd[nruns] = ext_wdata;
          nruns++;
        end
        if (nruns > 0) run_len[nruns-1]++;
        dtc++;
        ext_dtack = (dtc >= dt);
      end else begin
        dtc = 0;
        ext_dtack = 1'b0;
      end
      prev = ext_as;
      if (core_done) begin got = core_rdata; break; end
      if (waited > 200) begin chk(0, "access timeout", waited, 0); break; end
    end
    core_req = 1'b0; ext_dtack = 1'b0; cs_hit = '0; per_hit = 1'b0;
    @(negedge clk);
    chk(!core_done, "R12 done single cycle", core_done, 0);
  endtask

  task automatic t_wide_cs_read();
    cfg_cs_wide = 3'b111;
    access(24'h000120, 1, 1, 1, 16'h0, 4'b0010, 0, 3'b101, 100);
    chk(nruns == 1, "R13 one cycle", nruns, 1);
    chk(run_len[0] == 3, "R5 strobe length", run_len[0], 3);
    chk(run_uds[0] && run_lds[0] && !run_nar[0] && run_addr[0] == 24'h120, "R13 strobes/addr",
        run_addr[0], 24'h120);
    chk(got == wide_rd(24'h120), "R9 wide read", got, wide_rd(24'h120));
  endtask

  task automatic t_cs0_narrow_read();
    access(24'h000200, 1, 1, 1, 16'h0, 4'b0001, 0, 3'b101, 100);
    chk(nruns == 2, "R2 pin 0 gives two cycles", nruns, 2);
    chk(run_addr[0] == 24'h200 && run_addr[1] == 24'h201, "R6 address order", run_addr[1], 24'h201);
    chk(run_uds[0] && !run_lds[0] && run_uds[1] && !run_lds[1] && run_nar[1], "R7 lane strobes",
        {run_uds[1], run_lds[1]}, 2);
    chk(run_len[0] == 3 && run_len[1] == 3, "R5 split lengths", run_len[1], 3);
    chk(got == {byte_rd(24'h200), byte_rd(24'h201)}, "R9 reassembled word", got,
        {byte_rd(24'h200), byte_rd(24'h201)});
  endtask

  task automatic t_narrow_write();
    cfg_cs_wide = 3'b110;
    access(24'h000300, 1, 1, 0, 16'hBEEF, 4'b0010, 0, 3'b101, 100);
    chk(nruns == 2, "R3 cfg bit0 narrows match bit 1", nruns, 2);
    chk(run_wd[0] == 16'hBE00, "R7 even byte on upper lane", run_wd[0], 16'hBE00);
    chk(run_wd[1] == 16'hEF00, "R7 odd byte steered", run_wd[1], 16'hEF00);
  endtask

  task automatic t_cfg_bits();
    cfg_cs_wide = 3'b011;
    access(24'h000310, 1, 1, 1, 16'h0, 4'b0100, 0, 3'b101, 100);
    chk(nruns == 1, "R3 cfg bit1 wide", nruns, 1);
    access(24'h000310, 1, 1, 1, 16'h0, 4'b1000, 0, 3'b101, 100);
    chk(nruns == 2, "R3 cfg bit2 narrow", nruns, 2);
  endtask

  task automatic t_single_bytes();
    cfg_cs_wide = 3'b110;
    access(24'h000400, 0, 1, 0, 16'h1234, 4'b0010, 0, 3'b101, 100);
    chk(nruns == 1, "R8 odd byte one cycle", nruns, 1);
    chk(run_addr[0] == 24'h401 && run_wd[0] == 16'h3400, "R8 odd addr/data", run_wd[0], 16'h3400);
    access(24'h000410, 1, 0, 1, 16'h0, 4'b0010, 0, 3'b101, 100);
    chk(nruns == 1 && run_addr[0] == 24'h410, "R8 even byte one cycle", run_addr[0], 24'h410);
    chk(got == {byte_rd(24'h410), 8'h00}, "R9 unrequested byte zero", got, {byte_rd(24'h410), 8'h00});
  endtask

  task automatic t_unmatched();
    cfg_ext_wide = 1'b1;
    access(24'h000500, 1, 1, 1, 16'h0, 4'b0000, 0, 3'b101, 4);
    chk(nruns == 1 && run_len[0] == 4, "R4 wide waits for dtack", run_len[0], 4);
    chk(got == wide_rd(24'h500), "R4 wide read data", got, wide_rd(24'h500));
    cfg_ext_wide = 1'b0;
    access(24'h000510, 1, 1, 1, 16'h0, 4'b0000, 0, 3'b101, 2);
    chk(nruns == 2 && run_len[1] == 2 && run_nar[0], "R4 narrow unmatched", nruns, 2);
    cfg_ext_wide = 1'b1;
  endtask

  task automatic t_peripheral();
    per_rdata = 16'h5AC3;
    access(24'h000600, 1, 1, 1, 16'h0, 4'b0001, 1, 3'b101, 100);
    chk(nruns == 0, "R10 no external cycle", nruns, 0);
    chk(waited == 2, "R10 completion latency", waited, 2);
    chk(got == 16'h5AC3, "R10 peripheral data", got, 16'h5AC3);
  endtask

  task automatic t_fc_suppress();
    access(24'h000700, 1, 1, 1, 16'h0, 4'b0001, 0, 3'b111, 4);
    chk(nruns == 1 && !run_nar[0], "R11 uses unmatched width", nruns, 1);
    chk(run_len[0] == 4, "R11 ended by dtack", run_len[0], 4);
  endtask

  task automatic t_priority();
    cfg_cs_wide = 3'b111;
    access(24'h000800, 1, 1, 1, 16'h0, 4'b0011, 0, 3'b101, 100);
    chk(nruns == 2, "R12 lowest match wins", nruns, 2);
  endtask

  task automatic t_pin_resample();
    do_reset(1'b1);
    busw_pin = 1'b0;
    repeat (2) @(negedge clk);
    access(24'h000900, 1, 1, 1, 16'h0, 4'b0001, 0, 3'b101, 100);
    chk(nruns == 1, "R2 pin change after reset ignored", nruns, 1);
  endtask

  bit finished = 0;
  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    t_wide_cs_read();
    t_cs0_narrow_read();
    t_narrow_write();
    t_cfg_bits();
    t_single_bytes();
    t_unmatched();
    t_peripheral();
    t_fc_suppress();
    t_priority();
    t_pin_resample();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule